// File: doc/BRIEF.md
# Programmed and Interrupt-Driven I/O Port

This block sits on a simple processor bus and gives software a three-register window onto one slow peripheral. Software loads an outgoing datum, issues one of four command kinds (control, test, read, write) and learns of completion either by polling a status word or by taking a level interrupt. A single outgoing buffer and a single incoming buffer decouple the bus rate from the peripheral rate.

On the device side every command becomes a strobe with a command code. The strobe and the code are held until the peripheral signals ready. The address space is chosen at build time. With memory-mapped decoding the port answers ordinary bus reads and writes. With isolated decoding it answers only when the separate I/O-select line is high.

Top module: `pio_port`

## Requirements
- R1: The port answers only at BASE_ADDR+0 (data), +1 (status) and +2 (command). `bus_ack` rises in the cycle after such an access, and a read returns its data on `bus_rdata` in that same cycle. Any other address gets no acknowledge and changes no state.
- R2: A bus write to the data offset loads the outgoing buffer, which is driven on `dev_wdata`. A bus read of the data offset returns the incoming buffer.
- R3: A write to the command offset with the port idle starts a command. Bits [1:0] of that write give the kind (0 control, 1 test, 2 read, 3 write). `dev_cmd` carries that code, and `dev_strobe` is high from the next cycle on. Bit 7 of that write is the interrupt enable, and it is taken on every command-offset write.
- R4: When a read command completes, `dev_rdata` is captured into the incoming buffer.
- R5: When a test command completes, `dev_state` is captured into status bits [7:4]. Other commands leave those bits unchanged.
- R6: `dev_strobe`, `dev_cmd` and `dev_wdata` stay stable while `dev_ack` is low. The command completes on the first clock edge at which the strobe and `dev_ack` are both high, and the strobe is low from the next cycle.
- R7: Status bit 0 (ready) is set at completion and cleared when a new command starts. Bit 1 (busy) is high from the start of a command until its completion. All status bits are 0 after reset.
- R8: At completion, if the interrupt enable is 1, status bit 3 (pending) is set and `irq` goes high. If the enable is 0, neither changes.
- R9: A read of the data offset clears pending and drops `irq`. So does a status write with bit 3 set. A status write with bit 2 set clears the error bit. Writes to status bits 0, 1 and 7:4 have no effect.
- R10: A command write or a data write while busy sets status bit 2 (error). That write changes neither the running command nor the outgoing buffer.
- R11: With ISOLATED=1, an access with `bus_io` low is ignored. With ISOLATED=0, `bus_io` is ignored and ordinary accesses hit.
- R12: A command-offset read returns {enable, 5'b0, last command kind}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus access valid this cycle |
| bus_wr | input | 1 | 1 write, 0 read |
| bus_io | input | 1 | I/O-space select (isolated mode only) |
| bus_addr | input | ADDR_W | Bus address |
| bus_wdata | input | DATA_W | Bus write data |
| bus_rdata | output | DATA_W | Read data, valid with bus_ack |
| bus_ack | output | 1 | Access acknowledge, one cycle after the access |
| irq | output | 1 | Level interrupt (pending bit) |
| dev_strobe | output | 1 | Command strobe to the peripheral |
| dev_cmd | output | 2 | Command kind to the peripheral |
| dev_wdata | output | DATA_W | Outgoing buffer |
| dev_ack | input | 1 | Peripheral ready |
| dev_rdata | input | DATA_W | Peripheral datum for read commands |
| dev_state | input | 4 | Peripheral state for test commands |

## Verification
Every bus result belongs to the cycle after the access: the acknowledge, the read data and any register side effect. The same holds for device results: the strobe follows a command write by one cycle, and the status, `irq` and the strobe drop follow the edge at which the peripheral ready is sampled by one cycle. The bench drives at falling edges and holds each access for one cycle. A driver queues the expected read values, and a monitor compares them at the next falling edge, when `bus_ack` is high. Port checks on the device side are also taken at the falling edge that follows the relevant rising edge.

// File: rtl/pio_port.sv
module pio_port #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 'h40,
  parameter bit ISOLATED = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic              bus_io,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_ack,
  output logic              irq,
  output logic              dev_strobe,
  output logic [1:0]        dev_cmd,
  output logic [DATA_W-1:0] dev_wdata,
  input  logic              dev_ack,
  input  logic [DATA_W-1:0] dev_rdata,
  input  logic [3:0]        dev_state
);

  localparam logic [1:0] OFF_DATA = 2'd0;
  localparam logic [1:0] OFF_STAT = 2'd1;
  localparam logic [1:0] OFF_CTRL = 2'd2;
  localparam logic [1:0] K_TEST   = 2'd1;
  localparam logic [1:0] K_READ   = 2'd2;

  logic              ien_q, ready_q, err_q, pend_q;
  logic [DATA_W-1:0] in_q;
  logic [3:0]        dstate_q;
  logic [DATA_W-1:0] stat_word, ctrl_word, rd_mux;

  wire space_ok = ISOLATED ? bus_io : 1'b1;
  wire [1:0] off = bus_addr[1:0];
  wire hit = bus_sel && space_ok && (off != 2'd3)
             && (bus_addr[ADDR_W-1:2] == BASE_ADDR[ADDR_W-1:2]);
  wire wr_data = hit && bus_wr && (off == OFF_DATA);
  wire wr_stat = hit && bus_wr && (off == OFF_STAT);
  wire wr_ctrl = hit && bus_wr && (off == OFF_CTRL);
  wire rd_data = hit && !bus_wr && (off == OFF_DATA);
  wire busy    = dev_strobe;
  wire done    = dev_strobe && dev_ack;
  wire cmd_go  = wr_ctrl && !busy;

  assign irq = pend_q;

  always_comb begin
    stat_word = '0;
    stat_word[7:0] = {dstate_q, pend_q, err_q, busy, ready_q};
    ctrl_word = '0;
    ctrl_word[7] = ien_q;
    ctrl_word[1:0] = dev_cmd;
    case (off)
      OFF_DATA: rd_mux = in_q;
      OFF_STAT: rd_mux = stat_word;
      default:  rd_mux = ctrl_word;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_ack   <= 1'b0;
      bus_rdata <= '0;
    end else begin
      bus_ack <= hit;
      if (hit && !bus_wr) bus_rdata <= rd_mux;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dev_strobe <= 1'b0;
      dev_cmd    <= 2'd0;
      ien_q      <= 1'b0;
      dev_wdata  <= '0;
    end else begin
      if (done) dev_strobe <= 1'b0;
      else if (cmd_go) begin
        dev_strobe <= 1'b1;
        dev_cmd    <= bus_wdata[1:0];
      end
      if (wr_ctrl) ien_q <= bus_wdata[7];
      if (wr_data && !busy) dev_wdata <= bus_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ready_q  <= 1'b0;
      err_q    <= 1'b0;
      pend_q   <= 1'b0;
      in_q     <= '0;
      dstate_q <= 4'd0;
    end else begin
      if (done) ready_q <= 1'b1;
      else if (cmd_go) ready_q <= 1'b0;
      if ((wr_ctrl || wr_data) && busy) err_q <= 1'b1;
      else if (wr_stat && bus_wdata[2]) err_q <= 1'b0;
      if (done && ien_q) pend_q <= 1'b1;
      else if (rd_data || (wr_stat && bus_wdata[3])) pend_q <= 1'b0;
      if (done && dev_cmd == K_READ) in_q <= dev_rdata;
      if (done && dev_cmd == K_TEST) dstate_q <= dev_state;
    end
  end

  AST_STROBE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    dev_strobe && !dev_ack |=> dev_strobe && $stable(dev_cmd) && $stable(dev_wdata)); // R6
  AST_STROBE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    dev_strobe && dev_ack |=> !dev_strobe); // R6
  AST_ACK_NEEDS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ack |-> $past(bus_sel)); // R1
  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(dev_strobe && dev_ack && ien_q)); // R8

  generate
    if (ISOLATED) begin : g_iso_chk
      AST_IO_SPACE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ack |-> $past(bus_io)); // R11
    end
  endgenerate

endmodule

// File: tb/pio_port_tb.sv
module pio_port_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_sel = 1'b0, bus_wr = 1'b0, bus_io = 1'b1;
  logic [15:0] bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic        bus_ack, irq, dev_strobe;
  logic [1:0]  dev_cmd;
  logic [7:0]  dev_wdata;
  logic        dev_ack = 1'b0;
  logic [7:0]  dev_rdata = '0;
  logic [3:0]  dev_state = '0;

  logic [7:0]  mm_rdata, mm_wdata;
  logic        mm_ack, mm_irq, mm_strobe;
  logic [1:0]  mm_cmd;

  int checks = 0;
  int errors = 0;

  typedef struct { bit is_rd; logic [7:0] exp; string tag; } item_t;
  item_t sb_q[$];

  always #5 clk = ~clk;

  pio_port #(.ADDR_W(16), .DATA_W(8), .BASE_ADDR(16'h0040), .ISOLATED(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_io(bus_io),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack),
    .irq(irq), .dev_strobe(dev_strobe), .dev_cmd(dev_cmd), .dev_wdata(dev_wdata),
    .dev_ack(dev_ack), .dev_rdata(dev_rdata), .dev_state(dev_state));

  pio_port #(.ADDR_W(16), .DATA_W(8), .BASE_ADDR(16'h0040), .ISOLATED(1'b0)) dut_mm_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_io(bus_io),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(mm_rdata), .bus_ack(mm_ack),
    .irq(mm_irq), .dev_strobe(mm_strobe), .dev_cmd(mm_cmd), .dev_wdata(mm_wdata),
    .dev_ack(1'b0), .dev_rdata(8'h00), .dev_state(4'h0));

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic access(bit wr, logic [15:0] a, logic [7:0] d, bit io,
                        bit expect_ack, logic [7:0] exp, string tag);
    item_t it;
    if (expect_ack) begin
      it.is_rd = !wr; it.exp = exp; it.tag = tag;
      sb_q.push_back(it);
    end
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = wr; bus_addr = a; bus_wdata = d; bus_io = io;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; bus_io = 1'b1;
  endtask

  task automatic wr_reg(logic [15:0] a, logic [7:0] d, string tag);
    access(1'b1, a, d, 1'b1, 1'b1, 8'h00, tag);
  endtask

  task automatic rd_reg(logic [15:0] a, logic [7:0] exp, string tag);
    access(1'b0, a, 8'h00, 1'b1, 1'b1, exp, tag);
  endtask

  task automatic dev_respond(int waits, logic [7:0] rd, logic [3:0] st);
    for (int i = 0; i < waits; i++) begin
      @(negedge clk);
      chk("R6 strobe held", {15'd0, dev_strobe}, 16'd1);
    end
    dev_rdata = rd; dev_state = st; dev_ack = 1'b1;
    @(negedge clk);
    dev_ack = 1'b0;
    chk("R6 strobe dropped", {15'd0, dev_strobe}, 16'd0);
  endtask

  always @(negedge clk) begin
    if (rst_n && bus_ack) begin
      checks++;
      if (sb_q.size() == 0) begin
        errors++;
        $display("FAIL R1 unexpected ack actual=1 expected=0");
      end else begin
        item_t it;
        it = sb_q.pop_front();
        if (it.is_rd && bus_rdata !== it.exp) begin
          errors++;
          $display("FAIL %s actual=%0h expected=%0h", it.tag, bus_rdata, it.exp);
        end
      end
    end
  end

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R7 reset strobe", {15'd0, dev_strobe}, 16'd0);
    chk("R8 reset irq", {15'd0, irq}, 16'd0);
    rd_reg(16'h0041, 8'h00, "R7 reset status");

    // R11: io low ignored by isolated port, taken by memory-mapped port
    access(1'b1, 16'h0040, 8'h5A, 1'b0, 1'b0, 8'h00, "R11");
    chk("R11 mm ack", {15'd0, mm_ack}, 16'd1);
    chk("R11 mm data", {8'd0, mm_wdata}, 16'h005A);
    chk("R11 iso ignored", {8'd0, dev_wdata}, 16'h0000);

    // R1: foreign addresses
    access(1'b0, 16'h0043, 8'h00, 1'b1, 1'b0, 8'h00, "R1");
    access(1'b1, 16'h0044, 8'hFF, 1'b1, 1'b0, 8'h00, "R1");
    access(1'b1, 16'h0080, 8'hFF, 1'b1, 1'b0, 8'h00, "R1");
    chk("R1 foreign write no effect", {8'd0, dev_wdata}, 16'h0000);

    // R2 / R3: write command with interrupt enabled
    wr_reg(16'h0040, 8'hA5, "R2");
    chk("R2 out buffer", {8'd0, dev_wdata}, 16'h00A5);
    wr_reg(16'h0042, 8'h83, "R3");
    chk("R3 strobe", {15'd0, dev_strobe}, 16'd1);
    chk("R3 cmd write", {14'd0, dev_cmd}, 16'd3);
    rd_reg(16'h0041, 8'h02, "R7 busy");
    rd_reg(16'h0042, 8'h83, "R12 ctrl readback");

    // R10: writes while busy
    wr_reg(16'h0042, 8'h81, "R10");
    chk("R10 cmd kept", {14'd0, dev_cmd}, 16'd3);
    wr_reg(16'h0040, 8'h11, "R10");
    chk("R10 data kept", {8'd0, dev_wdata}, 16'h00A5);
    rd_reg(16'h0041, 8'h06, "R10 error");

    dev_respond(3, 8'h00, 4'h0);
    chk("R8 irq set", {15'd0, irq}, 16'd1);
    rd_reg(16'h0041, 8'h0D, "R7 R8 done status");

    // R9: write-1-to-clear
    wr_reg(16'h0041, 8'h0F, "R9");
    chk("R9 irq cleared", {15'd0, irq}, 16'd0);
    rd_reg(16'h0041, 8'h01, "R9 status cleared");

    // R4: read command, clear by data read
    wr_reg(16'h0042, 8'h82, "R4");
    chk("R3 cmd read", {14'd0, dev_cmd}, 16'd2);
    rd_reg(16'h0041, 8'h02, "R7 ready cleared");
    dev_respond(2, 8'h3C, 4'h7);
    chk("R8 irq read done", {15'd0, irq}, 16'd1);
    rd_reg(16'h0040, 8'h3C, "R4 captured");
    chk("R9 irq cleared by read", {15'd0, irq}, 16'd0);

    // R5 / R8: test command, interrupts off
    wr_reg(16'h0042, 8'h01, "R5");
    chk("R3 cmd test", {14'd0, dev_cmd}, 16'd1);
    dev_respond(1, 8'hEE, 4'h9);
    chk("R8 no irq when disabled", {15'd0, irq}, 16'd0);
    rd_reg(16'h0041, 8'h91, "R5 state captured");
    rd_reg(16'h0040, 8'h3C, "R4 buffer unchanged by test");

    // control command
    wr_reg(16'h0042, 8'h00, "R3");
    chk("R3 cmd control", {14'd0, dev_cmd}, 16'd0);
    rd_reg(16'h0041, 8'h92, "R7 busy control");
    dev_respond(0, 8'h00, 4'h2);
    rd_reg(16'h0041, 8'h91, "R5 state kept by control");

    repeat (3) @(negedge clk);
    chk("R1 all acks seen", sb_q.size(), 16'd0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule